// File: doc/BRIEF.md
# Predicated Integer-to-Condition-Field Vector Writer

This block sequences a vectorised move from an integer operand into a run of 4-bit condition fields, under control of an integer destination predicate. A start pulse captures the vector length, the first target field, the 64-bit predicate, the zeroing enable, a 4-bit mask, a 4-bit mode pattern and the least significant bit of the source operand. The block then walks the elements one per cycle. For element i it reads predicate bit i, counted from the arithmetic least significant bit, and targets condition field base+i. Fields are numbered in plain ascending order, with no reversal inside groups of eight.

An element whose predicate bit is set receives a 4-bit match word. Each bit k of that word is set when mask bit k is set and mode bit k equals the source bit. An element whose predicate bit is clear receives all zeros when zeroing is enabled. When zeroing is disabled, it receives no write at all. A separate input marks the source selector as register zero, which forces the source bit to zero. In that case an enabled element receives mask & ~mode, and this is how constant patterns can be set or cleared. Writes leave the block as a strobe, a field index and a data nibble, which go to the condition register file. A single-cycle done pulse follows the last element.

Top module: `int_cr_pred_writer`

## Requirements
- R1: While reset is held and in the first cycle after it, busy_o, wr_en_o and done_o are all low.
- R2: A start_i accepted while idle presents element i in the (i+1)-th cycle after the start edge, one element per cycle, with wr_idx_o = base_i + i.
- R3: Element i is governed by pred_i[i], where bit 0 is the least significant bit of the predicate.
- R4: For an element whose predicate bit is 1, wr_data_o bit k = mask_i[k] AND (mode_i[k] == source bit), and the write strobe is asserted.
- R5: When src_zero_i is 1, the source bit is taken as 0 whatever src_bit_i holds, so an enabled element receives mask_i & ~mode_i.
- R6: For an element whose predicate bit is 0 while zero_en_i is 1, the write strobe is asserted with wr_data_o = 4'b0000.
- R7: For an element whose predicate bit is 0 while zero_en_i is 0, no write strobe is issued and the target field keeps its value.
- R8: An element whose target index base_i + i exceeds 63 issues no write.
- R9: done_o is high for exactly one cycle, in the cycle after the last element (cycle vl_i+1 after the start edge), and busy_o is then low. With vl_i = 0, done_o rises in the first cycle after the start edge and no write is issued.
- R10: A start_i raised while an operation is in progress is ignored, and the operation in progress keeps the operands it captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (accepted only when idle) |
| vl_i | input | 7 | Vector length, 0 to 64 |
| base_i | input | 6 | First target condition field |
| pred_i | input | 64 | Destination predicate, bit 0 for element 0 |
| zero_en_i | input | 1 | Write zeros to masked-out elements |
| mask_i | input | 4 | Per-bit enable of the match word |
| mode_i | input | 4 | Per-bit value compared with the source bit |
| src_zero_i | input | 1 | Source selector is register zero; source bit forced to 0 |
| src_bit_i | input | 1 | Least significant bit of the source operand |
| busy_o | output | 1 | Elements are being issued |
| wr_en_o | output | 1 | Condition field write strobe |
| wr_idx_o | output | 6 | Index of the field being written |
| wr_data_o | output | 4 | Data for the field being written |
| done_o | output | 1 | One-cycle pulse after the last element |

## Verification
The assertions assume that start_i is a synchronous input and that vl_i never exceeds 64. They make no assumption about when start_i is raised. That point matters, because the property on operand stability while busy relies on the block ignoring a mid-run start. The stimulus keeps every vector length within 0 to 64. Some cases deliberately place base and length so that indices run past 63, and one case raises start_i during a run with a different mask to probe the ignore path. All inputs are driven on the falling edge.

// File: rtl/int_cr_pkg.sv
package int_cr_pkg;
  localparam int unsigned NIB_W = 4;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/icr_elem_seq.sv
module icr_elem_seq
  import int_cr_pkg::*;
#(
  parameter int unsigned MAX_VL = 64,
  localparam int unsigned EL_W = $clog2(MAX_VL),
  localparam int unsigned VL_W = $clog2(MAX_VL + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [VL_W-1:0] vl_i,
  output logic            load_o,
  output logic            busy_o,
  output logic            done_o,
  output logic [EL_W-1:0] elem_o
);
  seq_state_e      state_q, state_d;
  logic [EL_W-1:0] elem_q, elem_d;
  logic [VL_W-1:0] vl_q, vl_d;
  logic            last_el;

  assign load_o  = (state_q == ST_IDLE) && start_i;
  assign last_el = ({1'b0, elem_q} == (vl_q - 1'b1));

  always_comb begin
    state_d = state_q;
    elem_d  = elem_q;
    vl_d    = vl_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        vl_d    = vl_i;
        elem_d  = '0;
        state_d = (vl_i == '0) ? ST_DONE : ST_RUN;
      end
      ST_RUN: begin
        if (last_el) state_d = ST_DONE;
        else         elem_d  = elem_q + 1'b1;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      elem_q  <= '0;
      vl_q    <= '0;
    end else begin
      state_q <= state_d;
      elem_q  <= elem_d;
      vl_q    <= vl_d;
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign done_o = (state_q == ST_DONE);
  assign elem_o = elem_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_ELEM_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> elem_o == $past(elem_o) + 1'b1); // R2
  AST_ELEM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> {1'b0, elem_o} < vl_q); // R9
  AST_VL_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(vl_q)); // R10
endmodule

// File: rtl/icr_elem_map.sv
module icr_elem_map #(
  parameter int unsigned PRED_W     = 64,
  parameter int unsigned NUM_FIELDS = 64,
  localparam int unsigned EL_W = $clog2(PRED_W),
  localparam int unsigned F_W  = $clog2(NUM_FIELDS)
) (
  input  logic [PRED_W-1:0] pred_i,
  input  logic [EL_W-1:0]   elem_i,
  input  logic [F_W-1:0]    base_i,
  output logic              pred_bit_o,
  output logic [F_W-1:0]    idx_o,
  output logic              in_range_o
);
  localparam int unsigned SUM_W = ((F_W > EL_W) ? F_W : EL_W) + 1;
  logic [SUM_W-1:0] sum;

  // arithmetic bit order: element 0 uses the LSB
  assign pred_bit_o = pred_i[elem_i];
  assign sum        = SUM_W'(base_i) + SUM_W'(elem_i);
  assign in_range_o = (sum < SUM_W'(NUM_FIELDS));
  assign idx_o      = sum[F_W-1:0];
endmodule

// File: rtl/icr_match_unit.sv
module icr_match_unit
  import int_cr_pkg::*;
(
  input  logic [NIB_W-1:0] mask_i,
  input  logic [NIB_W-1:0] mode_i,
  input  logic             src_bit_i,
  output logic [NIB_W-1:0] match_o
);
  for (genvar k = 0; k < NIB_W; k++) begin : g_bit
    assign match_o[k] = mask_i[k] & ~(mode_i[k] ^ src_bit_i);
  end
endmodule

// File: rtl/int_cr_pred_writer.sv
module int_cr_pred_writer
  import int_cr_pkg::*;
#(
  parameter int unsigned PRED_W     = 64,
  parameter int unsigned NUM_FIELDS = 64,
  localparam int unsigned EL_W = $clog2(PRED_W),
  localparam int unsigned VL_W = $clog2(PRED_W + 1),
  localparam int unsigned F_W  = $clog2(NUM_FIELDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic [F_W-1:0]    base_i,
  input  logic [PRED_W-1:0] pred_i,
  input  logic              zero_en_i,
  input  logic [NIB_W-1:0]  mask_i,
  input  logic [NIB_W-1:0]  mode_i,
  input  logic              src_zero_i,
  input  logic              src_bit_i,
  output logic              busy_o,
  output logic              wr_en_o,
  output logic [F_W-1:0]    wr_idx_o,
  output logic [NIB_W-1:0]  wr_data_o,
  output logic              done_o
);
  logic              load;
  logic [EL_W-1:0]   elem;
  logic [PRED_W-1:0] pred_q;
  logic [F_W-1:0]    base_q;
  logic              zen_q;
  logic [NIB_W-1:0]  mask_q, mode_q;
  logic              sbit_q;
  logic              pred_bit, in_range;
  logic [NIB_W-1:0]  match;

  icr_elem_seq #(.MAX_VL(PRED_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .vl_i   (vl_i),
    .load_o (load),
    .busy_o (busy_o),
    .done_o (done_o),
    .elem_o (elem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_q <= '0;
      base_q <= '0;
      zen_q  <= 1'b0;
      mask_q <= '0;
      mode_q <= '0;
      sbit_q <= 1'b0;
    end else if (load) begin
      pred_q <= pred_i;
      base_q <= base_i;
      zen_q  <= zero_en_i;
      mask_q <= mask_i;
      mode_q <= mode_i;
      sbit_q <= src_bit_i & ~src_zero_i;
    end
  end

  icr_elem_map #(.PRED_W(PRED_W), .NUM_FIELDS(NUM_FIELDS)) u_map (
    .pred_i    (pred_q),
    .elem_i    (elem),
    .base_i    (base_q),
    .pred_bit_o(pred_bit),
    .idx_o     (wr_idx_o),
    .in_range_o(in_range)
  );

  icr_match_unit u_match (
    .mask_i   (mask_q),
    .mode_i   (mode_q),
    .src_bit_i(sbit_q),
    .match_o  (match)
  );

  assign wr_en_o   = busy_o && in_range && (pred_bit || zen_q);
  assign wr_data_o = pred_bit ? match : '0;

  AST_WR_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> busy_o); // R2
  AST_ZERO_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o && !pred_bit |-> wr_data_o == '0); // R6
  AST_DATA_IN_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_data_o & ~mask_q) == '0); // R4
  AST_OPS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(mask_q) && $stable(pred_q) && $stable(base_q)); // R10
  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) && wr_en_o && $past(wr_en_o)
      |-> wr_idx_o == $past(wr_idx_o) + 1'b1); // R2
endmodule

// File: tb/sim_int_cr_pred_writer.sv
module sim_int_cr_pred_writer;
  localparam time CLK_PERIOD = 10ns;
  localparam int NV = 7;

  typedef struct packed {
    logic [6:0]  vl;
    logic [5:0]  base;
    logic [63:0] pred;
    logic        zen;
    logic [3:0]  mask;
    logic [3:0]  mode;
    logic        srcz;
    logic        sbit;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{7'd8,  6'd0,  64'h0000_0000_0000_00A5, 1'b1, 4'hF, 4'h0, 1'b0, 1'b1},
    '{7'd5,  6'd8,  64'h0000_0000_0000_0002, 1'b1, 4'h3, 4'h0, 1'b1, 1'b1},
    '{7'd16, 6'd20, 64'h0000_0000_0000_0F0F, 1'b0, 4'hA, 4'hA, 1'b0, 1'b1},
    '{7'd64, 6'd0,  64'h8000_0000_0000_0001, 1'b0, 4'hC, 4'h5, 1'b0, 1'b0},
    '{7'd10, 6'd58, 64'h0000_0000_0000_03FF, 1'b1, 4'hF, 4'h9, 1'b0, 1'b1},
    '{7'd1,  6'd63, 64'h0000_0000_0000_0000, 1'b1, 4'hF, 4'h0, 1'b0, 1'b0},
    '{7'd33, 6'd30, 64'hFFFF_FFFF_0000_0000, 1'b1, 4'h6, 4'h0, 1'b0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [6:0] vl_i = '0;
  logic [5:0] base_i = '0;
  logic [63:0] pred_i = '0;
  logic       zero_en_i = 1'b0;
  logic [3:0] mask_i = '0, mode_i = '0;
  logic       src_zero_i = 1'b0, src_bit_i = 1'b0;
  logic       busy_o, wr_en_o, done_o;
  logic [5:0] wr_idx_o;
  logic [3:0] wr_data_o;

  int checks = 0, failures = 0;
  int cyc = 0;
  logic [3:0] cr_q [64];
  logic [3:0] exp_q [64];
  int writes, exp_writes, done_cyc, done_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_cr_pred_writer u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .vl_i(vl_i),
    .base_i(base_i), .pred_i(pred_i), .zero_en_i(zero_en_i),
    .mask_i(mask_i), .mode_i(mode_i), .src_zero_i(src_zero_i),
    .src_bit_i(src_bit_i), .busy_o(busy_o), .wr_en_o(wr_en_o),
    .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o), .done_o(done_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected <150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill_fields();
    for (int j = 0; j < 64; j++) begin
      cr_q[j]  = 4'(j) ^ 4'h5;
      exp_q[j] = cr_q[j];
    end
  endtask

  // model of the requirements, independent of the RTL
  task automatic expect_op(input vec_t v);
    logic s;
    s = v.srcz ? 1'b0 : v.sbit;
    exp_writes = 0;
    for (int i = 0; i < int'(v.vl); i++) begin
      int f;
      logic [3:0] nib;
      f = int'(v.base) + i;
      if (f > 63) continue;
      for (int k = 0; k < 4; k++) nib[k] = v.mask[k] && (v.mode[k] == s);
      if (v.pred[i]) begin exp_q[f] = nib; exp_writes++; end
      else if (v.zen) begin exp_q[f] = 4'h0; exp_writes++; end
    end
  endtask

  task automatic run_op(input vec_t v, input bit restart);
    @(negedge clk);
    vl_i = v.vl; base_i = v.base; pred_i = v.pred; zero_en_i = v.zen;
    mask_i = v.mask; mode_i = v.mode; src_zero_i = v.srcz; src_bit_i = v.sbit;
    start_i = 1'b1;
    writes = 0; done_cyc = -1; done_cnt = 0;
    for (int c = 1; c <= 80; c++) begin
      @(negedge clk);
      if (wr_en_o) begin cr_q[wr_idx_o] = wr_data_o; writes++; end
      if (done_o) begin done_cnt++; if (done_cyc < 0) done_cyc = c; end
      start_i = 1'b0;
      if (restart && c == 2) begin
        start_i = 1'b1; mask_i = ~v.mask; base_i = v.base + 6'd3; pred_i = ~v.pred;
      end
      if (restart && c == 3) begin
        mask_i = v.mask; base_i = v.base; pred_i = v.pred;
      end
      if (done_cyc > 0 && c >= done_cyc + 1) break;
    end
    start_i = 1'b0;
  endtask

  task automatic cmp_fields(input string req);
    int bad;
    bad = -1;
    for (int j = 0; j < 64; j++) if (cr_q[j] !== exp_q[j] && bad < 0) bad = j;
    if (bad < 0) check(1'b1, req, 0, 0);
    else begin
      $display("  first mismatching field %0d", bad);
      check(1'b0, req, cr_q[bad], exp_q[bad]);
    end
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!busy_o && !wr_en_o && !done_o, "R1 in reset", {busy_o, wr_en_o, done_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!busy_o && !wr_en_o && !done_o, "R1 after reset", {busy_o, wr_en_o, done_o}, 0);

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int t = 0; t < NV; t++) begin
      fill_fields();
      expect_op(TBL[t]);
      run_op(TBL[t], 1'b0);
      cmp_fields($sformatf("R2/R3/R4/R6/R8 fields vec%0d", t));
      check(writes == exp_writes, $sformatf("R7/R8 write count vec%0d", t), writes, exp_writes);
      check(done_cyc == int'(TBL[t].vl) + 1 && done_cnt == 1,
            $sformatf("R9 done timing vec%0d", t), done_cyc, int'(TBL[t].vl) + 1);
    end

    // R5: source forced zero with src_bit 1 and mode all ones gives zero
    begin
      vec_t v;
      v = '{7'd4, 6'd40, 64'hF, 1'b0, 4'hF, 4'hF, 1'b1, 1'b1};
      fill_fields(); expect_op(v); run_op(v, 1'b0);
      check(cr_q[41] == 4'h0, "R5 forced-zero source", cr_q[41], 0);
      cmp_fields("R5 fields");
    end

    // R9: zero length
    begin
      vec_t v;
      v = '{7'd0, 6'd5, 64'hFFFF, 1'b1, 4'hF, 4'h0, 1'b0, 1'b0};
      fill_fields(); expect_op(v); run_op(v, 1'b0);
      check(done_cyc == 1, "R9 zero-length done", done_cyc, 1);
      check(writes == 0, "R9 zero-length no write", writes, 0);
    end

    // R10: start while busy ignored
    begin
      vec_t v;
      v = '{7'd6, 6'd10, 64'h2D, 1'b1, 4'h5, 4'h1, 1'b0, 1'b1};
      fill_fields(); expect_op(v); run_op(v, 1'b1);
      cmp_fields("R10 restart ignored fields");
      check(done_cnt == 1 && done_cyc == 7, "R10 single done", done_cyc, 7);
      repeat (2) @(negedge clk);
      check(!busy_o && !done_o, "R10 idle after op", {busy_o, done_o}, 0);
    end

    // R7: untouched field keeps value when predicate 0, no zeroing
    begin
      vec_t v;
      v = '{7'd3, 6'd0, 64'h5, 1'b0, 4'hF, 4'h0, 1'b0, 1'b0};
      fill_fields(); expect_op(v); run_op(v, 1'b0);
      check(cr_q[1] == (4'd1 ^ 4'h5), "R7 field kept", cr_q[1], 4'd1 ^ 4'h5);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule